// File: doc/BRIEF.md
# Per-Pin Secure GPIO Access Filter

This block is the register bank of a general-purpose I/O port. It is split into several port groups, each serving up to 32 pins. Every group holds a direction register and an output-level register. Each also holds a 32-bit attribution register that labels every pin as either secured or open to non-secure software. A simple register bus carries a flag with each access that says whether the access came through the secure alias or the non-secure alias.

While the module-level protection input is high, the bank masks every non-secure access to the direction and output registers bit by bit. Writes to secured pins are dropped silently, with no error. Reads of secured pins return zero. Pins whose attribution bit is set stay fully reachable. Only secure software can change the attribution itself. When protection is low, non-secure accesses act exactly like secure ones.

Each register has alias offsets that clear, set or toggle only the bits written as one. These aliases pass through the same per-pin filter, so non-secure software can use atomic pin updates on its own pins without touching secured ones.

Top module: `gsec_port_bank`

## Requirements
- R1: After a synchronous active-high reset, the direction, output and attribution registers of every group are all zeros, so every pin starts secured.
- R2: Group g occupies addresses g*0x80 to g*0x80+0x7F. Direction is at offset 0x00 and output is at offset 0x10. Their clear, set and toggle aliases sit at +0x04, +0x08 and +0x0C from each register. Attribution is at offset 0x6C. Unmapped offsets, and groups at or above N_GROUPS, read 0 and ignore writes.
- R3: A secure access (bus_ns=0) reads and writes all 32 bits of the direction and output registers, whatever the attribution.
- R4: An attribution bit of 1 makes that pin non-secured, and non-secure accesses read and modify it freely.
- R5: With prot_en=1, a non-secure plain write stores (old & ~attr) | (wdata & attr), so secured bits keep their value and no error is raised.
- R6: With prot_en=1, a non-secure read of a direction or output offset returns 0 in every secured bit position.
- R7: Clear, set and toggle aliases change only the bits written as 1 (clear to 0, set to 1, invert). For non-secure accesses under protection, the write data is first ANDed with the attribution.
- R8: The attribution register is written only by secure accesses. Non-secure writes to it are ignored, and non-secure reads return its full value.
- R9: With prot_en=0, non-secure reads and writes behave exactly like secure ones.
- R10: Reads return data combinationally in the cycle the access is presented. Writes become visible on the outputs after the next rising clock edge.
- R11: A write to one group leaves every other group's registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prot_en | input | 1 | Enables per-pin filtering of non-secure accesses |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_ns | input | 1 | 1 = non-secure alias, 0 = secure alias |
| bus_addr | input | ADDR_W | Byte address: group in upper bits, offset in low 7 bits |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| dir_o | output | N_GROUPS*32 | Direction registers of all groups, group 0 in the low bits |
| out_o | output | N_GROUPS*32 | Output-level registers of all groups, group 0 in the low bits |

## Verification
The bench builds the bank with N_GROUPS=3. This gives a two-bit group field in which index 3 has no group behind it, so out-of-range decoding is exercised alongside three independent live groups. With three groups, the bench can also show that writes to a middle group leave both of its neighbours untouched. Every pin is used at full 32-bit width, so masks that split a register into a secured upper half and an open lower half reach both halves, including the top bit under toggle.

// File: rtl/gsec_pkg.sv
package gsec_pkg;

    localparam int PINS      = 32;
    localparam int OFF_W     = 7;
    localparam int MAX_GRP_W = 8;

    typedef logic [PINS-1:0] pin_vec_t;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_DIR  = 2'd1,
        RK_OUT  = 2'd2,
        RK_ATTR = 2'd3
    } reg_kind_e;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_CLR   = 2'd1,
        OP_SET   = 2'd2,
        OP_TGL   = 2'd3
    } wr_op_e;

    typedef struct packed {
        reg_kind_e kind;
        wr_op_e    op;
    } reg_dec_t;

    localparam logic [OFF_W-1:0] OFF_DIR  = 7'h00;
    localparam logic [OFF_W-1:0] OFF_OUT  = 7'h10;
    localparam logic [OFF_W-1:0] OFF_ATTR = 7'h6C;

    function automatic reg_dec_t decode_offset(input logic [OFF_W-1:0] off);
        reg_dec_t d;
        d.kind = RK_NONE;
        d.op   = OP_WRITE;
        if (off[OFF_W-1:4] == OFF_DIR[OFF_W-1:4] && off[1:0] == 2'b00) begin
            d.kind = RK_DIR;
            d.op   = wr_op_e'(off[3:2]);
        end else if (off[OFF_W-1:4] == OFF_OUT[OFF_W-1:4] && off[1:0] == 2'b00) begin
            d.kind = RK_OUT;
            d.op   = wr_op_e'(off[3:2]);
        end else if (off == OFF_ATTR) begin
            d.kind = RK_ATTR;
            d.op   = OP_WRITE;
        end
        return d;
    endfunction

    // Bits a given access may reach: all of them unless filtering applies.
    function automatic pin_vec_t reach_mask(input logic ns,
                                            input logic prot,
                                            input pin_vec_t attr);
        return (ns && prot) ? attr : '1;
    endfunction

    function automatic pin_vec_t apply_op(input wr_op_e   op,
                                          input pin_vec_t old,
                                          input pin_vec_t wd,
                                          input pin_vec_t mask);
        pin_vec_t eff;
        pin_vec_t res;
        eff = wd & mask;
        case (op)
            OP_WRITE: res = (old & ~mask) | eff;
            OP_CLR:   res = old & ~eff;
            OP_SET:   res = old | eff;
            OP_TGL:   res = old ^ eff;
            default:  res = old;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/gsec_addr_dec.sv
module gsec_addr_dec
    import gsec_pkg::*;
#(
    parameter int N_GROUPS = 2,
    parameter int GRP_W    = 1,
    parameter int ADDR_W   = OFF_W + GRP_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [GRP_W-1:0]  grp_idx,
    output logic              grp_hit,
    output reg_dec_t          dec
);

    always_comb begin
        grp_idx = addr[ADDR_W-1:OFF_W];
        grp_hit = (int'({1'b0, grp_idx}) < N_GROUPS);
        dec     = decode_offset(addr[OFF_W-1:0]);
    end

endmodule

// File: rtl/gsec_group.sv
module gsec_group
    import gsec_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sel,
    input  logic     wr,
    input  logic     ns,
    input  logic     prot,
    input  reg_dec_t dec,
    input  pin_vec_t wdata,
    output pin_vec_t dir_q,
    output pin_vec_t out_q,
    output pin_vec_t attr_q,
    output pin_vec_t rdata
);

    pin_vec_t mask;
    logic     wr_en;

    always_comb begin
        mask  = reach_mask(ns, prot, attr_q);
        wr_en = sel && wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            out_q  <= '0;
            attr_q <= '0;
        end else if (wr_en) begin
            case (dec.kind)
                RK_DIR:  dir_q <= apply_op(dec.op, dir_q, wdata, mask);
                RK_OUT:  out_q <= apply_op(dec.op, out_q, wdata, mask);
                RK_ATTR: if (!ns) attr_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (dec.kind)
            RK_DIR:  rdata = dir_q & mask;
            RK_OUT:  rdata = out_q & mask;
            RK_ATTR: rdata = attr_q;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/gsec_port_bank.sv
module gsec_port_bank
    import gsec_pkg::*;
#(
    parameter  int N_GROUPS = 2,
    localparam int GRP_W    = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1,
    localparam int ADDR_W   = OFF_W + GRP_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     prot_en,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic                     bus_ns,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [PINS-1:0]          bus_wdata,
    output logic [PINS-1:0]          bus_rdata,
    output logic [N_GROUPS*PINS-1:0] dir_o,
    output logic [N_GROUPS*PINS-1:0] out_o
);

    logic [GRP_W-1:0]          grp_idx;
    logic                      grp_hit;
    reg_dec_t                  dec;
    pin_vec_t                  grp_rd   [N_GROUPS];
    logic [N_GROUPS*PINS-1:0]  attr_all;

    gsec_addr_dec #(
        .N_GROUPS (N_GROUPS),
        .GRP_W    (GRP_W),
        .ADDR_W   (ADDR_W)
    ) u_dec (
        .addr    (bus_addr),
        .grp_idx (grp_idx),
        .grp_hit (grp_hit),
        .dec     (dec)
    );

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        logic     sel_g;
        pin_vec_t dir_g;
        pin_vec_t out_g;
        pin_vec_t attr_g;

        assign sel_g = bus_sel && grp_hit && (int'({1'b0, grp_idx}) == g);

        gsec_group u_grp (
            .clk    (clk),
            .rst    (rst),
            .sel    (sel_g),
            .wr     (bus_wr),
            .ns     (bus_ns),
            .prot   (prot_en),
            .dec    (dec),
            .wdata  (bus_wdata),
            .dir_q  (dir_g),
            .out_q  (out_g),
            .attr_q (attr_g),
            .rdata  (grp_rd[g])
        );

        assign dir_o[g*PINS +: PINS]    = dir_g;
        assign out_o[g*PINS +: PINS]    = out_g;
        assign attr_all[g*PINS +: PINS] = attr_g;
    end

    always_comb begin
        bus_rdata = '0;
        for (int g = 0; g < N_GROUPS; g++) begin
            if (bus_sel && !bus_wr && grp_hit && int'({1'b0, grp_idx}) == g)
                bus_rdata = grp_rd[g];
        end
    end

endmodule

// File: rtl/gsec_chk.sv
module gsec_chk
    import gsec_pkg::*;
#(
    parameter int N_GROUPS = 2,
    parameter int GRP_W    = 1,
    parameter int ADDR_W   = OFF_W + GRP_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     prot_en,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic                     bus_ns,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [PINS-1:0]          bus_wdata,
    input  logic [PINS-1:0]          bus_rdata,
    input  logic [N_GROUPS*PINS-1:0] dir_o,
    input  logic [N_GROUPS*PINS-1:0] out_o,
    input  logic [N_GROUPS*PINS-1:0] attr_all
);

    logic [GRP_W-1:0] c_grp;
    logic [OFF_W-1:0] c_off;
    logic             c_valid;
    pin_vec_t         c_attr;

    always_comb begin
        c_grp   = bus_addr[ADDR_W-1:OFF_W];
        c_off   = bus_addr[OFF_W-1:0];
        c_valid = int'({1'b0, c_grp}) < N_GROUPS;
        c_attr  = '0;
        for (int g = 0; g < N_GROUPS; g++)
            if (int'({1'b0, c_grp}) == g) c_attr = attr_all[g*PINS +: PINS];
    end

    logic             full_wr_q;
    logic [GRP_W-1:0] full_grp_q;
    pin_vec_t         full_data_q;
    pin_vec_t         full_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_wr_q   <= 1'b0;
            full_grp_q  <= '0;
            full_data_q <= '0;
        end else begin
            full_wr_q   <= bus_sel && bus_wr && c_valid && c_off == OFF_DIR
                           && (!bus_ns || !prot_en);
            full_grp_q  <= c_grp;
            full_data_q <= bus_wdata;
        end
    end

    always_comb begin
        full_seen = '0;
        for (int g = 0; g < N_GROUPS; g++)
            if (int'({1'b0, full_grp_q}) == g) full_seen = dir_o[g*PINS +: PINS];
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $fell(rst) |-> (dir_o == '0 && out_o == '0 && attr_all == '0));

    // R5
    ns_dir_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_ns && prot_en)
        |=> ((dir_o ^ $past(dir_o)) & ~$past(attr_all)) == '0);

    // R5 R7
    ns_out_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_ns && prot_en)
        |=> ((out_o ^ $past(out_o)) & ~$past(attr_all)) == '0);

    // R6
    ns_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_ns && prot_en && c_valid && c_off != OFF_ATTR)
        |-> (bus_rdata & ~c_attr) == '0);

    // R8
    attr_ns_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_ns) |=> $stable(attr_all));

    // R3 R9
    full_write_chk: assert property (@(posedge clk) disable iff (rst)
        full_wr_q |-> full_seen == full_data_q);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_wr) |=> ($stable(dir_o) && $stable(out_o) && $stable(attr_all)));

endmodule

bind gsec_port_bank gsec_chk #(
    .N_GROUPS (N_GROUPS),
    .GRP_W    (GRP_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .prot_en   (prot_en),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_ns    (bus_ns),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .dir_o     (dir_o),
    .out_o     (out_o),
    .attr_all  (attr_all)
);

// File: tb/tb_gsec_port_bank.sv
module tb_gsec_port_bank;

    localparam int NG     = 3;
    localparam int GW     = 2;
    localparam int AW     = 7 + GW;
    localparam int P      = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            prot_en = 1'b1;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic            bus_ns = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [P-1:0]    bus_wdata = '0;
    logic [P-1:0]    bus_rdata;
    logic [NG*P-1:0] dir_o;
    logic [NG*P-1:0] out_o;

    always #4 clk = ~clk;

    gsec_port_bank #(.N_GROUPS(NG)) dut (
        .clk       (clk),
        .rst       (rst),
        .prot_en   (prot_en),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_ns    (bus_ns),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dir_o     (dir_o),
        .out_o     (out_o)
    );

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [P-1:0] exp;
        string        tag;
    } sb_item_t;

    sb_item_t sbq[$];

    logic [P-1:0] m_dir  [4];
    logic [P-1:0] m_out  [4];
    logic [P-1:0] m_attr [4];

    task automatic chk(input string tag, input logic [P-1:0] act, input logic [P-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    function automatic logic [P-1:0] vis_mask(input int g, input bit ns);
        return (ns && prot_en) ? m_attr[g] : '1;
    endfunction

    function automatic logic [P-1:0] model_read(input int g, input logic [6:0] off, input bit ns);
        if (g >= NG) return '0;
        case (off)
            7'h00, 7'h04, 7'h08, 7'h0C: return m_dir[g] & vis_mask(g, ns);
            7'h10, 7'h14, 7'h18, 7'h1C: return m_out[g] & vis_mask(g, ns);
            7'h6C:                      return m_attr[g];
            default:                    return '0;
        endcase
    endfunction

    function automatic logic [P-1:0] model_op(input logic [1:0] op, input logic [P-1:0] old,
                                              input logic [P-1:0] d, input logic [P-1:0] m);
        case (op)
            2'd0:    return (old & ~m) | (d & m);
            2'd1:    return old & ~(d & m);
            2'd2:    return old | (d & m);
            default: return old ^ (d & m);
        endcase
    endfunction

    task automatic model_write(input int g, input logic [6:0] off, input bit ns, input logic [P-1:0] d);
        if (g >= NG) return;
        if (off[6:4] == 3'd0 && off[1:0] == 2'b00)
            m_dir[g] = model_op(off[3:2], m_dir[g], d, vis_mask(g, ns));
        else if (off[6:4] == 3'd1 && off[1:0] == 2'b00)
            m_out[g] = model_op(off[3:2], m_out[g], d, vis_mask(g, ns));
        else if (off == 7'h6C && !ns)
            m_attr[g] = d;
    endtask

    // Driver: presents one access per cycle, a read also queues its expectation.
    task automatic acc(input bit w, input int g, input logic [6:0] off, input bit ns,
                       input logic [P-1:0] d, input string tag);
        sb_item_t it;
        @(posedge clk);
        #1;
        bus_sel   = 1'b1;
        bus_wr    = w;
        bus_ns    = ns;
        bus_addr  = {g[GW-1:0], off};
        bus_wdata = d;
        if (w) begin
            model_write(g, off, ns, d);
        end else begin
            it.exp = model_read(g, off, ns);
            it.tag = tag;
            sbq.push_back(it);
        end
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
    endtask

    // Monitor: compares read data mid-cycle against the queued expectation.
    always @(negedge clk) begin
        if (!rst && bus_sel && !bus_wr) begin
            if (sbq.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL scoreboard: unexpected read %08h expected none", bus_rdata);
            end else begin
                sb_item_t it;
                it = sbq.pop_front();
                chk(it.tag, bus_rdata, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int g = 0; g < 4; g++) begin
            m_dir[g] = '0; m_out[g] = '0; m_attr[g] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        for (int g = 0; g < NG; g++) begin
            chk("R1 dir reset", dir_o[g*P +: P], 32'h0);
            chk("R1 out reset", out_o[g*P +: P], 32'h0);
        end
        acc(0, 0, 7'h6C, 0, 0, "R1 attr reset");
        acc(0, 2, 7'h6C, 0, 0, "R1 attr reset g2");

        // All pins secured: non-secure traffic is shut out.
        acc(1, 0, 7'h00, 1, 32'hFFFF_FFFF, "");
        acc(0, 0, 7'h00, 0, 0, "R5 ns write dropped");
        acc(1, 0, 7'h00, 0, 32'hA5A5_5A5A, "");
        acc(0, 0, 7'h00, 0, 0, "R3 secure readback");
        acc(0, 0, 7'h00, 1, 0, "R6 ns read zero");

        acc(1, 0, 7'h6C, 1, 32'h0000_00FF, "");
        acc(0, 0, 7'h6C, 0, 0, "R8 ns attr write ignored");
        acc(1, 0, 7'h6C, 0, 32'h0000_FFFF, "");
        acc(0, 0, 7'h6C, 1, 0, "R8 ns attr read");
        acc(0, 0, 7'h00, 1, 0, "R4 R6 ns partial read");
        acc(1, 0, 7'h00, 1, 32'h1234_5678, "");
        acc(0, 0, 7'h00, 0, 0, "R5 masked merge");
        idle();
        chk("R5 merge at port", dir_o[0 +: P], 32'hA5A5_5678);

        // Atomic aliases on the output register.
        acc(1, 0, 7'h18, 1, 32'hFFFF_FFFF, "");
        acc(0, 0, 7'h10, 0, 0, "R7 ns set");
        acc(1, 0, 7'h14, 1, 32'h0000_00F0, "");
        acc(0, 0, 7'h10, 0, 0, "R7 ns clear");
        acc(1, 0, 7'h1C, 1, 32'hFFFF_0003, "");
        acc(1, 0, 7'h1C, 0, 32'h8000_0000, "");
        acc(0, 0, 7'h10, 0, 0, "R7 toggle both aliases");
        acc(0, 0, 7'h1C, 1, 0, "R7 R6 ns read via alias");
        acc(1, 0, 7'h08, 0, 32'h0000_0001, "");
        acc(1, 0, 7'h04, 0, 32'h8000_0000, "");
        acc(0, 0, 7'h00, 0, 0, "R7 secure dir set clear");
        idle();
        chk("R7 out port", out_o[0 +: P], 32'h8000_FF0C);

        // Groups and address decode.
        acc(1, 1, 7'h00, 0, 32'h0F0F_0F0F, "");
        acc(0, 0, 7'h00, 0, 0, "R11 group0 untouched");
        acc(0, 2, 7'h00, 0, 0, "R11 group2 untouched");
        acc(0, 1, 7'h00, 0, 0, "R2 group1 base");
        acc(1, 1, 7'h40, 0, 32'hFFFF_FFFF, "");
        acc(0, 1, 7'h40, 0, 0, "R2 unmapped read zero");
        acc(0, 1, 7'h00, 0, 0, "R2 unmapped write ignored");
        acc(1, 3, 7'h00, 0, 32'hFFFF_FFFF, "");
        acc(0, 3, 7'h00, 0, 0, "R2 absent group reads zero");
        idle();
        chk("R2 absent group g0", dir_o[0*P +: P], 32'hA5A5_5679 & 32'h7FFF_FFFF);
        chk("R2 absent group g1", dir_o[1*P +: P], 32'h0F0F_0F0F);
        chk("R2 absent group g2", dir_o[2*P +: P], 32'h0);

        // R10: write visible only after the edge, read in the same cycle.
        acc(1, 2, 7'h10, 0, 32'hCAFE_0001, "");
        @(negedge clk);
        chk("R10 before edge", out_o[2*P +: P], 32'h0);
        idle();
        chk("R10 after edge", out_o[2*P +: P], 32'hCAFE_0001);
        acc(0, 2, 7'h10, 0, 0, "R10 same-cycle read");

        // R9: protection off opens every pin to non-secure accesses.
        acc(0, 1, 7'h00, 1, 0, "R6 g1 hidden while protected");
        idle();
        prot_en = 1'b0;
        acc(0, 1, 7'h00, 1, 0, "R9 ns read unfiltered");
        acc(1, 1, 7'h00, 1, 32'hFFFF_0000, "");
        acc(0, 1, 7'h00, 0, 0, "R9 ns write unfiltered");
        acc(1, 1, 7'h6C, 1, 32'hFFFF_FFFF, "");
        acc(0, 1, 7'h6C, 0, 0, "R8 R9 attr still secure-only");
        idle();
        chk("R9 port", dir_o[1*P +: P], 32'hFFFF_0000);
        prot_en = 1'b1;
        acc(0, 1, 7'h00, 1, 0, "R6 filter back on");
        idle();

        repeat (2) @(posedge clk);
        if (sbq.size() != 0) begin
            n_tests++;
            n_fail++;
            $display("FAIL scoreboard: %0d left expected 0", sbq.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule